// File: doc/BRIEF.md
# Timer-Driven PWM Compare Channel

This block produces a pulse-width-modulated output from its own 16-bit time base. A programmable prescaler divides the clock by 1, 8, 64 or 256 and produces count ticks. The counter climbs from zero to the value in the period register and then returns to zero. The period therefore lasts (period + 1) × ratio clocks, where the clock is the instruction-rate clock, four oscillator periods. The output is high from the start of each period until the counter reaches the active duty value, and low for the rest of the period.

Software places a new duty value in a shadow register at any time. The value is moved into the active duty register only when the channel is enabled or when the counter wraps, so a period never mixes two duty values. Each wrap sets a sticky timer flag, which reaches the interrupt output when its enable is 1. The compare-match flag is never set while the channel runs in PWM mode.

Sleep stops the time base and the output holds its level. Idle does the same unless both the channel and the timer are configured to keep running.

The channel is a three-state machine:
- `ST_OFF`: disabled. The output is low and the counter is held at zero.
- `ST_HIGH`: the output is high.
- `ST_LOW`: the output is low.

Transitions:
- enable: from `ST_OFF` to `ST_HIGH`, or to `ST_LOW` if the duty value being latched is zero.
- match: from `ST_HIGH` to `ST_LOW`, when a tick moves the counter onto the active duty value.
- wrap: from `ST_HIGH` or `ST_LOW`, at rollover, to `ST_HIGH`, or to `ST_LOW` if the new duty value is zero.
- disable: from any state to `ST_OFF`, when `ch_en` is 0.

Top module: `ocpwm_channel`

## Requirements
- R1: While `ch_en` is 0, `pwm_out` is 0 and `count` is 0, one clock after `ch_en` is sampled low. After reset, both flags are also 0.
- R2: `pre_sel` selects the tick ratio: 00 is 1, 01 is 8, 10 is 64 and 11 is 256 clocks per tick. `count` runs 0..period and then wraps to 0, so one period is (period+1)×ratio clocks. The prescaler restarts from zero whenever `tmr_en` or `ch_en` is 0.
- R3: For an active duty D with 0 < D ≤ period, `pwm_out` is high while `count` < D and low from `count` = D to the end of the period. A full period therefore has D×ratio high clocks.
- R4: An active duty of 0 keeps `pwm_out` low for the whole period.
- R5: An active duty greater than the period register keeps `pwm_out` high for the whole period.
- R6: The shadow duty is copied to the active duty only on enable and at rollover. A shadow write in the same cycle as the rollover is used for the period that follows.
- R7: `tmr_flag` is set by each rollover and stays set until `tmr_flag_clr`; a set in the same cycle wins over a clear. `tmr_irq` is `tmr_flag` AND `tmr_ie`.
- R8: In PWM operation `cmp_flag` is never set, so `cmp_irq` stays 0 whatever `cmp_ie` is.
- R9: While `sleep` is 1, `count` and `pwm_out` hold their values. Counting resumes from there when `sleep` returns to 0.
- R10: While `idle` is 1, the channel counts only if `ch_idle_stop` is 0, `tmr_idle_stop` is 0 and `tmr_en` is 1; otherwise it holds. When `tmr_en` is 0, the counter holds in any mode.
- R11: On enable, the first period starts at `count` 0 with `pwm_out` high, unless the duty value being latched is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | 1 | Channel enable (PWM mode on) |
| tmr_en | input | 1 | Time base enable |
| ch_idle_stop | input | 1 | Channel stops in idle when 1 |
| tmr_idle_stop | input | 1 | Timer stops in idle when 1 |
| sleep | input | 1 | Sleep mode, freezes the time base |
| idle | input | 1 | Idle mode |
| pre_sel | input | 2 | Prescale select |
| prd_we | input | 1 | Period register write strobe |
| prd_wdata | input | 16 | Period write value |
| duty_we | input | 1 | Shadow duty write strobe |
| duty_wdata | input | 16 | Shadow duty write value |
| tmr_flag_clr | input | 1 | Clears the timer flag |
| cmp_flag_clr | input | 1 | Clears the compare flag |
| tmr_ie | input | 1 | Timer interrupt enable |
| cmp_ie | input | 1 | Compare interrupt enable |
| pwm_out | output | 1 | PWM output |
| count | output | 16 | Time base value |
| tmr_flag | output | 1 | Sticky rollover flag |
| cmp_flag | output | 1 | Sticky compare flag |
| tmr_irq | output | 1 | Enabled timer interrupt |
| cmp_irq | output | 1 | Enabled compare interrupt |

## Verification
The assertions check several rules on every cycle:
- a disabled channel forces the output low and the counter to zero;
- sleep freezes the counter and the output;
- each rollover leaves the timer flag set;
- the active duty changes only at a rollover or an enable;
- a zero active duty never shows a high output.

The bench scenarios are needed for the properties that span whole periods:
- the high-time and period counts under each prescale ratio;
- the saturating cases with duty equal to the period and duty above it;
- a duty write that lands mid-period or exactly on the wrap;
- each idle gating combination.

// File: rtl/ocpwm_pkg.sv
package ocpwm_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } pwm_state_e;

    localparam int FLAG_TMR = 0;
    localparam int FLAG_CMP = 1;
    localparam int NUM_FLAGS = 2;

    // Last prescaler count before a tick, per select code.
    function automatic int unsigned presc_limit(input logic [1:0] sel);
        case (sel)
            2'd0:    return 0;
            2'd1:    return 7;
            2'd2:    return 63;
            default: return 255;
        endcase
    endfunction

endpackage

// File: rtl/ocpwm_prescaler.sv
module ocpwm_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;

    assign lim  = PRE_W'(ocpwm_pkg::presc_limit(sel));
    assign tick = run && (pre_q >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clear) begin
            pre_q <= '0;
        end else if (run) begin
            if (pre_q >= lim) begin
                pre_q <= '0;
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end
endmodule

// File: rtl/ocpwm_timebase.sv
module ocpwm_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic             prd_we,
    input  logic [CNT_W-1:0] prd_wdata,
    output logic [CNT_W-1:0] count,
    output logic             rollover
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] prd_q;

    assign count    = cnt_q;
    assign rollover = tick && (cnt_q == prd_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == prd_q) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prd_q <= '1;
        end else if (prd_we) begin
            prd_q <= prd_wdata;
        end
    end
endmodule

// File: rtl/ocpwm_duty_buf.sv
module ocpwm_duty_buf #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             load,
    output logic [CNT_W-1:0] duty_next,
    output logic [CNT_W-1:0] duty_act
);
    logic [CNT_W-1:0] shadow_q;
    logic [CNT_W-1:0] act_q;

    // A write in the load cycle is taken straight into the active register.
    assign duty_next = we ? wdata : shadow_q;
    assign duty_act  = act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            act_q    <= '0;
        end else begin
            shadow_q <= duty_next;
            if (load) begin
                act_q <= duty_next;
            end
        end
    end
endmodule

// File: rtl/ocpwm_flags.sv
module ocpwm_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] ie,
    output logic [N-1:0] flag,
    output logic [N-1:0] irq
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic f_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                f_q <= 1'b0;
            end else if (set[i]) begin
                f_q <= 1'b1;
            end else if (clr[i]) begin
                f_q <= 1'b0;
            end
        end
        assign flag[i] = f_q;
        assign irq[i]  = f_q & ie[i];
    end
endmodule

// File: rtl/ocpwm_channel.sv
module ocpwm_channel #(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ch_en,
    input  logic             tmr_en,
    input  logic             ch_idle_stop,
    input  logic             tmr_idle_stop,
    input  logic             sleep,
    input  logic             idle,
    input  logic [1:0]       pre_sel,
    input  logic             prd_we,
    input  logic [CNT_W-1:0] prd_wdata,
    input  logic             duty_we,
    input  logic [CNT_W-1:0] duty_wdata,
    input  logic             tmr_flag_clr,
    input  logic             cmp_flag_clr,
    input  logic             tmr_ie,
    input  logic             cmp_ie,
    output logic             pwm_out,
    output logic [CNT_W-1:0] count,
    output logic             tmr_flag,
    output logic             cmp_flag,
    output logic             tmr_irq,
    output logic             cmp_irq
);
    import ocpwm_pkg::*;

    pwm_state_e state_q, state_d;

    logic             state_on;
    logic             gate_ok;
    logic             run;
    logic             tick;
    logic             rollover;
    logic             load_duty;
    logic             cmp_hit;
    logic             next_zero;
    logic [CNT_W-1:0] duty_next;
    logic [CNT_W-1:0] duty_act;
    logic [CNT_W-1:0] cnt_inc;
    logic [NUM_FLAGS-1:0] flg_set, flg_clr, flg_ie, flg_q, flg_irq;

    // Sleep always stops the clocks; idle stops them unless both sides keep running.
    assign gate_ok   = !sleep && !(idle && (ch_idle_stop || tmr_idle_stop));
    assign state_on  = (state_q != ST_OFF);
    assign run       = ch_en && tmr_en && state_on && gate_ok;
    assign cnt_inc   = count + CNT_W'(1);
    assign cmp_hit   = tick && !rollover && (cnt_inc == duty_act);
    assign next_zero = (duty_next == '0);
    assign load_duty = ((state_q == ST_OFF) && ch_en) || rollover;

    ocpwm_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!(tmr_en && ch_en)),
        .run   (run),
        .sel   (pre_sel),
        .tick  (tick)
    );

    ocpwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (!ch_en),
        .tick      (tick),
        .prd_we    (prd_we),
        .prd_wdata (prd_wdata),
        .count     (count),
        .rollover  (rollover)
    );

    ocpwm_duty_buf #(.CNT_W(CNT_W)) u_duty (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (duty_we),
        .wdata     (duty_wdata),
        .load      (load_duty),
        .duty_next (duty_next),
        .duty_act  (duty_act)
    );

    // Compare-match events do not exist in PWM mode, so that flag has no set source.
    always_comb begin
        flg_set           = '0;
        flg_set[FLAG_TMR] = rollover;
        flg_set[FLAG_CMP] = 1'b0;
        flg_clr           = '0;
        flg_clr[FLAG_TMR] = tmr_flag_clr;
        flg_clr[FLAG_CMP] = cmp_flag_clr;
        flg_ie            = '0;
        flg_ie[FLAG_TMR]  = tmr_ie;
        flg_ie[FLAG_CMP]  = cmp_ie;
    end

    ocpwm_flags #(.N(NUM_FLAGS)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flg_set),
        .clr   (flg_clr),
        .ie    (flg_ie),
        .flag  (flg_q),
        .irq   (flg_irq)
    );

    assign tmr_flag = flg_q[FLAG_TMR];
    assign cmp_flag = flg_q[FLAG_CMP];
    assign tmr_irq  = flg_irq[FLAG_TMR];
    assign cmp_irq  = flg_irq[FLAG_CMP];

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (ch_en) begin
                    state_d = next_zero ? ST_LOW : ST_HIGH;   // enable
                end
            end
            ST_HIGH: begin
                if (!ch_en) begin
                    state_d = ST_OFF;                         // disable
                end else if (rollover) begin
                    state_d = next_zero ? ST_LOW : ST_HIGH;   // wrap
                end else if (cmp_hit) begin
                    state_d = ST_LOW;                         // match
                end
            end
            ST_LOW: begin
                if (!ch_en) begin
                    state_d = ST_OFF;                         // disable
                end else if (rollover) begin
                    state_d = next_zero ? ST_LOW : ST_HIGH;   // wrap
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        pwm_out = (state_q == ST_HIGH);
    end
endmodule

// File: rtl/ocpwm_channel_chk.sv
module ocpwm_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ch_en,
    input logic             sleep,
    input logic             pwm_out,
    input logic [CNT_W-1:0] count,
    input logic             rollover,
    input logic             tmr_flag,
    input logic [CNT_W-1:0] duty_act,
    input logic             state_on
);
    assert_disabled_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en |=> (!pwm_out && count == '0));

    assert_sleep_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && ch_en && $past(ch_en)) |=> ($stable(count) && $stable(pwm_out)));

    assert_wrap_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rollover |=> tmr_flag);

    assert_duty_latch_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_on && $past(state_on) && !$stable(duty_act)) |-> $past(rollover));

    assert_zero_duty_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_on && duty_act == '0) |-> !pwm_out);
endmodule

bind ocpwm_channel ocpwm_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ch_en    (ch_en),
    .sleep    (sleep),
    .pwm_out  (pwm_out),
    .count    (count),
    .rollover (rollover),
    .tmr_flag (tmr_flag),
    .duty_act (duty_act),
    .state_on (state_on)
);

// File: tb/sim_ocpwm_channel.sv
`timescale 1ns/1ps
module sim_ocpwm_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ch_en = 0, tmr_en = 0, ch_idle_stop = 0, tmr_idle_stop = 0;
    logic        sleep = 0, idle = 0;
    logic [1:0]  pre_sel = 2'd0;
    logic        prd_we = 0, duty_we = 0;
    logic [15:0] prd_wdata = 0, duty_wdata = 0;
    logic        tmr_flag_clr = 0, cmp_flag_clr = 0, tmr_ie = 0, cmp_ie = 0;
    logic        pwm_out, tmr_flag, cmp_flag, tmr_irq, cmp_irq;
    logic [15:0] count;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    int m_pre = 0, m_cnt = 0, m_out = 0, m_duty = 0, m_sh = 0, m_prd = 65535;
    int m_on = 0, m_tf = 0, m_cf = 0;

    // window accumulators
    int acc_n = 0, acc_hi = 0, acc_top = 0, acc_csum = 0, acc_first_out = 0, acc_first_cnt = 0;
    int top_val = 9;

    always #10 clk = ~clk;

    ocpwm_channel u0 (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .tmr_en(tmr_en),
        .ch_idle_stop(ch_idle_stop), .tmr_idle_stop(tmr_idle_stop),
        .sleep(sleep), .idle(idle), .pre_sel(pre_sel),
        .prd_we(prd_we), .prd_wdata(prd_wdata),
        .duty_we(duty_we), .duty_wdata(duty_wdata),
        .tmr_flag_clr(tmr_flag_clr), .cmp_flag_clr(cmp_flag_clr),
        .tmr_ie(tmr_ie), .cmp_ie(cmp_ie),
        .pwm_out(pwm_out), .count(count), .tmr_flag(tmr_flag),
        .cmp_flag(cmp_flag), .tmr_irq(tmr_irq), .cmp_irq(cmp_irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int ratio_of(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 8;
            2'd2: return 64;
            default: return 256;
        endcase
    endfunction

    // Behavioural model advanced on each edge, compared 5 ns later.
    always @(posedge clk) begin
        int new_sh;
        int roll;
        int gate;
        roll = 0;
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_out = 0; m_duty = 0; m_sh = 0;
            m_prd = 65535; m_on = 0; m_tf = 0; m_cf = 0;
        end else begin
            new_sh = duty_we ? int'(duty_wdata) : m_sh;
            gate = (!sleep && !(idle && (ch_idle_stop || tmr_idle_stop))) ? 1 : 0;
            if (!ch_en) begin
                m_on = 0; m_cnt = 0; m_out = 0; m_pre = 0;
            end else if (m_on == 0) begin
                m_on = 1; m_duty = new_sh; m_out = (new_sh != 0) ? 1 : 0; m_pre = 0;
            end else if (!tmr_en) begin
                m_pre = 0;
            end else if (gate == 1) begin
                if (m_pre >= ratio_of(pre_sel) - 1) begin
                    m_pre = 0;
                    if (m_cnt == m_prd) begin
                        m_cnt = 0; m_duty = new_sh; m_out = (new_sh != 0) ? 1 : 0; roll = 1;
                    end else begin
                        m_cnt = (m_cnt + 1) % 65536;
                        if (m_cnt == m_duty) m_out = 0;
                    end
                end else begin
                    m_pre++;
                end
            end
            if (prd_we) m_prd = int'(prd_wdata);
            m_sh = new_sh;
            if (roll == 1) m_tf = 1;
            else if (tmr_flag_clr) m_tf = 0;
            if (cmp_flag_clr) m_cf = 0;
        end
        #5;
        if (rst_n) begin
            chk("R3", "model pwm_out", int'(pwm_out), m_out);
            chk("R2", "model count", int'(count), m_cnt);
            chk("R7", "model tmr_flag", int'(tmr_flag), m_tf);
            chk("R7", "model tmr_irq", int'(tmr_irq), m_tf & int'(tmr_ie));
            chk("R8", "model cmp_flag", int'(cmp_flag), m_cf);
            chk("R8", "model cmp_irq", int'(cmp_irq), m_cf & int'(cmp_ie));
        end
        if (acc_n == 0) begin
            acc_first_out = int'(pwm_out);
            acc_first_cnt = int'(count);
        end
        acc_n++;
        acc_hi += int'(pwm_out);
        acc_csum += int'(count);
        if (int'(count) == top_val) acc_top++;
    end

    // called at a negedge; collects n samples
    task automatic win(input int n);
        acc_n = 0; acc_hi = 0; acc_top = 0; acc_csum = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic set_prd(input int v);
        @(negedge clk); prd_we = 1; prd_wdata = 16'(v);
        @(negedge clk); prd_we = 0;
    endtask

    task automatic set_duty(input int v);
        @(negedge clk); duty_we = 1; duty_wdata = 16'(v);
        @(negedge clk); duty_we = 0;
    endtask

    task automatic wait_count(input int v);
        do begin
            @(posedge clk); #5;
        end while (int'(count) != v);
    endtask

    task automatic restart(input int sel, input int prd, input int duty);
        @(negedge clk); ch_en = 0; pre_sel = 2'(sel);
        set_prd(prd);
        set_duty(duty);
        top_val = prd;
        @(negedge clk); ch_en = 1;
    endtask

    task automatic frozen_check(input string req, input int n);
        int c0, p0, moves;
        moves = 0;
        @(posedge clk); #5;
        c0 = int'(count); p0 = int'(pwm_out);
        repeat (n) begin
            @(posedge clk); #5;
            if (int'(count) != c0 || int'(pwm_out) != p0) moves++;
        end
        chk(req, "changes while frozen", moves, 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R1", "reset pwm_out", int'(pwm_out), 0);
        chk("R1", "reset count", int'(count), 0);
        chk("R1", "reset tmr_flag", int'(tmr_flag), 0);
        chk("R1", "reset cmp_flag", int'(cmp_flag), 0);
        rst_n = 1;
        tmr_en = 1; tmr_ie = 1; cmp_ie = 1;
        set_prd(9);
        set_duty(3);

        // disabled: output low, counter zero
        win(6);
        chk("R1", "high samples while disabled", acc_hi, 0);
        chk("R1", "count sum while disabled", acc_csum, 0);

        // enable, ratio 1, period 10, duty 3
        ch_en = 1;
        win(30);
        chk("R11", "first sample pwm_out", acc_first_out, 1);
        chk("R11", "first sample count", acc_first_cnt, 0);
        chk("R3", "high samples over 3 periods", acc_hi, 9);
        chk("R2", "top-count samples over 3 periods", acc_top, 3);
        chk("R7", "tmr_flag after rollovers", int'(tmr_flag), 1);
        chk("R7", "tmr_irq with enable", int'(tmr_irq), 1);
        tmr_ie = 0; #1;
        chk("R7", "tmr_irq masked", int'(tmr_irq), 0);
        chk("R8", "cmp_flag in PWM", int'(cmp_flag), 0);
        chk("R8", "cmp_irq in PWM", int'(cmp_irq), 0);

        // clear away from a rollover, then see the next rollover set it again
        wait_count(3);
        @(negedge clk); tmr_flag_clr = 1;
        @(negedge clk); tmr_flag_clr = 0;
        chk("R7", "tmr_flag after clear", int'(tmr_flag), 0);
        wait_count(0);
        chk("R7", "tmr_flag set by next rollover", int'(tmr_flag), 1);
        @(negedge clk); tmr_ie = 1;

        // disable forces low/zero
        ch_en = 0;
        @(negedge clk);
        chk("R1", "pwm_out after disable", int'(pwm_out), 0);
        chk("R1", "count after disable", int'(count), 0);

        // mid-period duty write waits for the boundary
        ch_en = 1;
        acc_n = 0; acc_hi = 0; acc_top = 0; acc_csum = 0;
        @(negedge clk); duty_we = 1; duty_wdata = 16'd2;
        @(negedge clk); duty_we = 0;
        repeat (8) @(negedge clk);
        chk("R6", "high samples in period of mid write", acc_hi, 3);
        win(10);
        chk("R6", "high samples in following period", acc_hi, 2);

        // write in the rollover cycle is used right away
        wait_count(9);
        @(negedge clk); duty_we = 1; duty_wdata = 16'd5;
        acc_n = 0; acc_hi = 0; acc_top = 0; acc_csum = 0;
        @(negedge clk); duty_we = 0;
        repeat (9) @(negedge clk);
        chk("R6", "high samples after write on rollover", acc_hi, 5);

        // duty equal to period
        restart(0, 9, 9);
        win(20);
        chk("R3", "high samples duty==period", acc_hi, 18);

        // zero duty
        restart(0, 9, 0);
        win(20);
        chk("R11", "first sample with zero duty", acc_first_out, 0);
        chk("R4", "high samples duty 0", acc_hi, 0);

        // duty above period
        restart(0, 9, 12);
        win(20);
        chk("R5", "high samples duty>period", acc_hi, 20);

        // prescale 8
        restart(1, 3, 2);
        win(64);
        chk("R2", "high clocks ratio 8", acc_hi, 32);
        chk("R2", "top-count clocks ratio 8", acc_top, 16);

        // prescale 64
        restart(2, 1, 1);
        win(128);
        chk("R2", "high clocks ratio 64", acc_hi, 64);

        // prescale 256
        restart(3, 1, 1);
        win(512);
        chk("R2", "high clocks ratio 256", acc_hi, 256);
        chk("R2", "top-count clocks ratio 256", acc_top, 256);

        // sleep
        restart(0, 9, 3);
        repeat (4) @(negedge clk);
        sleep = 1;
        frozen_check("R9", 20);
        sleep = 0;
        win(10);
        chk("R9", "resume after sleep top-count", acc_top, 1);
        chk("R9", "resume after sleep high samples", acc_hi, 3);

        // idle gating
        idle = 1;
        win(10);
        chk("R10", "idle with both stops 0 runs", acc_top, 1);
        ch_idle_stop = 1;
        frozen_check("R10", 12);
        ch_idle_stop = 0; tmr_idle_stop = 1;
        frozen_check("R10", 12);
        tmr_idle_stop = 0; tmr_en = 0;
        frozen_check("R10", 12);
        tmr_en = 1; idle = 0; ch_idle_stop = 1;
        win(10);
        chk("R10", "stop bit ignored outside idle", acc_top, 1);
        ch_idle_stop = 0;
        win(4);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule